// File: doc/BRIEF.md
# Hex-Coded Multicycle 8-bit Processor Core

This block is a small multicycle processor that runs programs held in a byte-wide memory outside the core. The same memory holds code and data. Each instruction is 16 bits long and fills two neighbouring bytes. The core keeps sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction word. It works through fetch, execute and, for some opcodes, extra memory or rotate states.

An instruction has four 4-bit fields. The top nibble is the opcode. The other three name registers, or together with the low byte form an 8-bit constant or address. The opcodes cover:

- memory load and store
- immediate load and register copy
- wrap-around add, OR, AND and XOR
- right rotation by a variable count
- a jump taken when a register equals register 0
- halt

The memory answers a read one clock after it sees the address. Writes are one-cycle strobes. Holding reset high loads the program counter from the start-address input and clears the halted flag.

Top module: `hexcpu_core`

## Requirements
- R1: While `rst` is high, `halted` is 0 and `mem_we` is 0. On the cycle after `rst` falls, `mem_addr` equals the `start_addr` value present at the last reset edge, and the first fetch reads from there.
- R2: An instruction at address P is read big-endian. `mem[P]` gives bits 15:8: opcode in 15:12 and first field in 11:8. `mem[P+1]` gives bits 7:0: second field in 7:4 and third field in 3:0. The counter then advances to P+2. Programs may start at odd addresses.
- R3: Opcode 1 (`1RXY`) loads register R from memory byte XY. Opcode 2 (`2RXY`) loads the constant XY into register R.
- R4: Opcode 3 (`3RXY`) writes register R to memory byte XY with a single-cycle `mem_we` pulse.
- R5: Opcode 4 (`4xAB`) copies register A (bits 7:4) into register B (bits 3:0). Bits 11:8 are ignored.
- R6: Opcode 5 (`5RST`) writes (S + T) mod 256 into register R.
- R7: Opcodes 7, 8 and 9 (`xRST`) write S OR T, S AND T and S XOR T, respectively, into register R.
- R8: Opcode A (`AR0X`) rotates register R right by one bit per step, X times, with bit 0 moving to bit 7. X = 0 leaves R unchanged, and X = 8 returns the original value.
- R9: Opcode B (`BRXY`) loads XY into the program counter when register R equals register 0; otherwise the next instruction in sequence runs. With R = 0 the jump is always taken.
- R10: Opcode C halts the core. `halted` then stays 1 and no further memory write occurs until reset.
- R11: Opcodes 0, 6, D, E and F change no register and no memory byte; they only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts execution at `start_addr` |
| start_addr | input | 8 | Address of the first instruction, sampled during reset |
| halted | output | 1 | High after a halt instruction, until reset |
| mem_addr | output | 8 | Registered memory address |
| mem_wdata | output | 8 | Registered memory write data |
| mem_we | output | 1 | Registered write strobe, one cycle per store |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |

## Verification
The assertions assume three things about the inputs:

- The memory returns the byte at `mem_addr` exactly one clock later.
- Reset is held across at least one rising edge.
- `start_addr` is steady at the edge where reset is last sampled high.

The testbench memory model has read-before-write, one-cycle read latency. The bench holds reset for two cycles and changes `start_addr` and the memory image only while the core is in reset or halted. Register contents are observed solely through store instructions placed in each program.

// File: rtl/hexcpu_pkg.sv
package hexcpu_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int IW     = 16;
  localparam int NREG   = 16;
  localparam int FIELDW = 4;

  localparam logic [3:0] OPC_LDM = 4'h1;
  localparam logic [3:0] OPC_LDI = 4'h2;
  localparam logic [3:0] OPC_STM = 4'h3;
  localparam logic [3:0] OPC_MOV = 4'h4;
  localparam logic [3:0] OPC_ADD = 4'h5;
  localparam logic [3:0] OPC_IOR = 4'h7;
  localparam logic [3:0] OPC_AND = 4'h8;
  localparam logic [3:0] OPC_XOR = 4'h9;
  localparam logic [3:0] OPC_ROT = 4'hA;
  localparam logic [3:0] OPC_JEQ = 4'hB;
  localparam logic [3:0] OPC_HLT = 4'hC;

  typedef enum logic [3:0] {
    ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_EXEC,
    ST_LDWAIT, ST_LDDONE, ST_STDONE, ST_ROTATE, ST_HALT
  } cpu_state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_IOR, ALU_AND, ALU_XOR, ALU_ROR
  } alu_op_e;
endpackage

// File: rtl/hexcpu_regfile.sv
module hexcpu_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra_s,
  input  logic [$clog2(NREG)-1:0] ra_t,
  input  logic [$clog2(NREG)-1:0] ra_r,
  output logic [DW-1:0]           rd_s,
  output logic [DW-1:0]           rd_t,
  output logic [DW-1:0]           rd_r,
  output logic [DW-1:0]           rd_zero
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd_s    = regs[ra_s];
  assign rd_t    = regs[ra_t];
  assign rd_r    = regs[ra_r];
  assign rd_zero = regs[0];
endmodule

// File: rtl/hexcpu_alu.sv
module hexcpu_alu
  import hexcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_IOR: y = a | b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      ALU_ROR: y = {a[0], a[DW-1:1]};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/hexcpu_ctrl.sv
module hexcpu_ctrl
  import hexcpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] start_addr,
  output logic          halted,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [FW-1:0] f_r,
  output logic [FW-1:0] f_s,
  output logic [FW-1:0] f_t,
  input  logic [DW-1:0] rd_s,
  input  logic [DW-1:0] rd_t,
  input  logic [DW-1:0] rd_r,
  input  logic [DW-1:0] rd_zero,
  output alu_op_e       alu_op,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_y,
  output logic          rf_we,
  output logic [FW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  localparam int IWID = 4 * FW;
  localparam logic [AW-1:0] STEP1 = AW'(1);
  localparam logic [AW-1:0] STEP2 = AW'(2);

  cpu_state_e      state;
  logic [AW-1:0]   pc;
  logic [IWID-1:0] ir;
  logic [FW-1:0]   rot_cnt;
  logic [FW-1:0]   opc;
  logic [AW-1:0]   xy;

  assign opc = ir[IWID-1 -: FW];
  assign f_r = ir[3*FW-1 -: FW];
  assign f_s = ir[2*FW-1 -: FW];
  assign f_t = ir[FW-1:0];
  assign xy  = AW'(ir[2*FW-1:0]);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = f_r;
    rf_wdata = alu_y;
    alu_op   = ALU_ADD;
    alu_a    = rd_s;
    alu_b    = rd_t;
    case (state)
      ST_EXEC: begin
        case (opc)
          OPC_LDI: begin rf_we = 1'b1; rf_wdata = DW'(xy); end
          OPC_MOV: begin rf_we = 1'b1; rf_waddr = f_t; rf_wdata = rd_s; end
          OPC_ADD: begin rf_we = 1'b1; alu_op = ALU_ADD; end
          OPC_IOR: begin rf_we = 1'b1; alu_op = ALU_IOR; end
          OPC_AND: begin rf_we = 1'b1; alu_op = ALU_AND; end
          OPC_XOR: begin rf_we = 1'b1; alu_op = ALU_XOR; end
          default: rf_we = 1'b0;
        endcase
      end
      ST_LDDONE: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
      ST_ROTATE: begin rf_we = 1'b1; alu_op = ALU_ROR; alu_a = rd_r; end
      default: rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH0;
      pc        <= start_addr;
      mem_addr  <= start_addr;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      halted    <= 1'b0;
      ir        <= '0;
      rot_cnt   <= '0;
    end else begin
      case (state)
        ST_FETCH0: begin
          mem_addr <= pc + STEP1;
          state    <= ST_FETCH1;
        end
        ST_FETCH1: begin
          ir[IWID-1 -: DW] <= mem_rdata;
          state            <= ST_FETCH2;
        end
        ST_FETCH2: begin
          ir[DW-1:0] <= mem_rdata;
          pc         <= pc + STEP2;
          state      <= ST_EXEC;
        end
        ST_EXEC: begin
          case (opc)
            OPC_LDM: begin
              mem_addr <= xy;
              state    <= ST_LDWAIT;
            end
            OPC_STM: begin
              mem_addr  <= xy;
              mem_wdata <= rd_r;
              mem_we    <= 1'b1;
              state     <= ST_STDONE;
            end
            OPC_ROT: begin
              if (f_t == '0) begin
                mem_addr <= pc;
                state    <= ST_FETCH0;
              end else begin
                rot_cnt <= f_t;
                state   <= ST_ROTATE;
              end
            end
            OPC_JEQ: begin
              if (rd_r == rd_zero) begin
                pc       <= xy;
                mem_addr <= xy;
              end else begin
                mem_addr <= pc;
              end
              state <= ST_FETCH0;
            end
            OPC_HLT: begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
            default: begin
              mem_addr <= pc;
              state    <= ST_FETCH0;
            end
          endcase
        end
        ST_LDWAIT: state <= ST_LDDONE;
        ST_LDDONE: begin
          mem_addr <= pc;
          state    <= ST_FETCH0;
        end
        ST_STDONE: begin
          mem_we   <= 1'b0;
          mem_addr <= pc;
          state    <= ST_FETCH0;
        end
        ST_ROTATE: begin
          rot_cnt <= rot_cnt - FW'(1);
          if (rot_cnt == FW'(1)) begin
            mem_addr <= pc;
            state    <= ST_FETCH0;
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH0;
      endcase
    end
  end

  // R1: first cycle out of reset presents the start address
  assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == $past(start_addr) && !halted && !mem_we));

  // R2: second instruction byte comes from the next address
  assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH1) |-> (mem_addr == $past(mem_addr) + STEP1));

  // R4: store strobe lasts exactly one cycle
  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8: rotation state never runs with an exhausted count
  assert_rot_count_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ROTATE) |-> (rot_cnt != '0));

  // R9: equal registers redirect the next fetch to the target byte
  assert_jump_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OPC_JEQ && rd_r == rd_zero)
      |=> (mem_addr == $past(xy)));

  // R10: halt is sticky and silent
  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we));
endmodule

// File: rtl/hexcpu_core.sv
module hexcpu_core
  import hexcpu_pkg::*;
#(
  parameter int DATA_W = hexcpu_pkg::DW,
  parameter int ADDR_W = hexcpu_pkg::AW,
  parameter int REGS   = hexcpu_pkg::NREG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              halted,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int FW = $clog2(REGS);

  logic [FW-1:0]     f_r, f_s, f_t, rf_waddr;
  logic [DATA_W-1:0] rd_s, rd_t, rd_r, rd_zero;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y, rf_wdata;
  logic              rf_we;
  alu_op_e           alu_op;

  hexcpu_ctrl #(.DW(DATA_W), .AW(ADDR_W), .FW(FW)) u_ctrl (
    .clk(clk), .rst(rst), .start_addr(start_addr), .halted(halted),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .f_r(f_r), .f_s(f_s), .f_t(f_t),
    .rd_s(rd_s), .rd_t(rd_t), .rd_r(rd_r), .rd_zero(rd_zero),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  hexcpu_regfile #(.DW(DATA_W), .NREG(REGS)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_s(f_s), .ra_t(f_t), .ra_r(f_r),
    .rd_s(rd_s), .rd_t(rd_t), .rd_r(rd_r), .rd_zero(rd_zero)
  );

  hexcpu_alu #(.DW(DATA_W)) u_alu (
    .op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y)
  );
endmodule

// File: tb/tb_hexcpu_core.sv
module tb_hexcpu_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] start_addr = 8'h00;
  logic       halted;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;

  logic [7:0] mem [256];
  logic       clr = 1'b0;
  logic       ld_en = 1'b0;
  logic [7:0] ld_a = 8'h00, ld_d = 8'h00;
  int checks = 0, failures = 0, post_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexcpu_core dut (
    .clk(clk), .rst(rst), .start_addr(start_addr), .halted(halted),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hC0;
    end else if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (halted && mem_we) post_wr++;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wipe();
    @(negedge clk); ld_en = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
  endtask

  task automatic put16(input logic [7:0] a, input logic [15:0] w);
    poke(a, w[15:8]);
    poke(a + 8'd1, w[7:0]);
  endtask

  task automatic put_prog(input logic [7:0] a, input logic [15:0] words [$]);
    foreach (words[i]) put16(a + 8'(2 * i), words[i]);
  endtask

  task automatic run_from(input logic [7:0] s);
    @(negedge clk); ld_en = 1'b0; rst = 1'b1; start_addr = s;
    repeat (2) @(negedge clk);
    chk("R1 addr in reset", mem_addr, s);
    chk("R1 halted in reset", {7'd0, halted}, 8'h00);
    chk("R1 we in reset", {7'd0, mem_we}, 8'h00);
    rst = 1'b0;
    for (int n = 0; n < 3000 && !halted; n++) @(negedge clk);
    chk("R10 reached halt", {7'd0, halted}, 8'h01);
  endtask

  task automatic t_sample();  // R3 R4 R6 R10
    wipe();
    put_prog(8'hA0, '{16'h156C, 16'h166D, 16'h5056, 16'h306E, 16'hC000, 16'h306F});
    poke(8'h6C, 8'h01); poke(8'h6D, 8'h02); poke(8'h6F, 8'hAA);
    post_wr = 0;
    run_from(8'hA0);
    chk("R3/R6 sum stored", mem[8'h6E], 8'h03);
    repeat (30) @(negedge clk);
    chk("R10 halted stays", {7'd0, halted}, 8'h01);
    chk("R10 no store after halt", mem[8'h6F], 8'hAA);
    chk("R10 no write strobe after halt", 8'(post_wr), 8'h00);
  endtask

  task automatic t_logic();  // R5 R6 R7
    wipe();
    put_prog(8'h00, '{16'h215A, 16'h22C3, 16'h7312, 16'h8412, 16'h9512, 16'h5612,
                      16'h4017, 16'h287F, 16'h2901, 16'h5A89, 16'h3380, 16'h3481,
                      16'h3582, 16'h3683, 16'h3784, 16'h3A85, 16'hC000});
    run_from(8'h00);
    chk("R7 or", mem[8'h80], 8'hDB);
    chk("R7 and", mem[8'h81], 8'h42);
    chk("R7 xor", mem[8'h82], 8'h99);
    chk("R6 add wrap", mem[8'h83], 8'h1D);
    chk("R5 move", mem[8'h84], 8'h5A);
    chk("R6 add overflow", mem[8'h85], 8'h80);
  endtask

  task automatic t_rotate();  // R8
    wipe();
    put_prog(8'h00, '{16'h2165, 16'hA101, 16'h3190, 16'h2265, 16'hA200, 16'h3291,
                      16'h2365, 16'hA308, 16'h3392, 16'h2481, 16'hA403, 16'h3493,
                      16'h2501, 16'hA50F, 16'h3594, 16'hC000});
    run_from(8'h00);
    chk("R8 rotate 1", mem[8'h90], 8'hB2);
    chk("R8 rotate 0", mem[8'h91], 8'h65);
    chk("R8 rotate 8", mem[8'h92], 8'h65);
    chk("R8 rotate 3", mem[8'h93], 8'h30);
    chk("R8 rotate 15", mem[8'h94], 8'h02);
  endtask

  task automatic t_jump();  // R9
    wipe();
    put_prog(8'h40, '{16'h2011, 16'h2111, 16'h2222, 16'hB260, 16'h23AA, 16'hB150,
                      16'h23BB, 16'hC000, 16'h33A0, 16'hB058, 16'h23CC, 16'hC000,
                      16'h33A1, 16'hC000});
    put_prog(8'h60, '{16'h23EE, 16'h33A0, 16'h33A1, 16'hC000});
    run_from(8'h40);
    chk("R9 untaken then taken", mem[8'hA0], 8'hAA);
    chk("R9 unconditional", mem[8'hA1], 8'hAA);
  endtask

  task automatic t_odd_start();  // R2 R3
    wipe();
    put_prog(8'h21, '{16'h12F0, 16'h32F1, 16'hC000});
    poke(8'hF0, 8'h5E);
    run_from(8'h21);
    chk("R2/R3 odd start load", mem[8'hF1], 8'h5E);
  endtask

  task automatic t_nop();  // R11
    wipe();
    put_prog(8'h00, '{16'h213C, 16'h0123, 16'h6111, 16'hD100, 16'hE123,
                      16'hF1FF, 16'h31C0, 16'hC000});
    run_from(8'h00);
    chk("R11 register untouched", mem[8'hC0], 8'h3C);
    chk("R11 memory untouched", mem[8'hC1], 8'hC0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_sample();
    t_logic();
    t_rotate();
    t_jump();
    t_odd_start();
    t_nop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule